// File: doc/BRIEF.md
# Self-Checking Reversible 2-to-4 Decoder

This block is a purely combinational 2-to-4 decoder made from three controlled-swap
(Fredkin) reversible gates. Each gate sits inside a testable cell that produces two
parity bits. The first bit is the seed XORed with the parity of the gate's inputs. The
second is the seed XORed with the parity of the gate's outputs, taken after an identity
pass. A controlled-swap gate keeps the number of ones between its input and output, so
the two bits of a healthy cell agree.

A final test cell XORs the six parity bits with a control bit `e` to form the error
flag. The flag therefore equals `e` while every gate behaves. It takes the opposite
value when one gate output bit is wrong. The check runs alongside normal decoding and
does not alter the decode function.

A 9-bit fault vector can flip any gate output. It lets the surrounding environment
rehearse single-bit faults and single event upsets.

Top module: `rev_decoder_ot`

## Requirements
- R1: With `fault` all zero, `dec[i]` is 1 exactly when `sel == i`, so `dec` is one-hot. `sel[1]` is the control of cell 0, and `sel[0]` is the control of cells 1 and 2.
- R2: The cells compute a controlled swap from control a and data (b, c) to outputs (a, b, c) when a=0 and to (a, c, b) when a=1. Cell 0 takes (sel[1], 1, 0). Cell 1 takes (sel[0], sel[1], 0) and drives `dec[2]` and `dec[3]` from its second and third outputs. Cell 2 takes (sel[0], ~sel[1], 0) and drives `dec[0]` and `dec[1]`.
- R3: For cell k, `par[2k]` equals `seed[k]` XOR the parity of the cell's three inputs. `par[2k+1]` equals `seed[k]` XOR the parity of its three outputs after fault injection.
- R4: With `sel`=2'b10, `seed`=0, `e`=0 and no fault, `dec`=4'b0100, `par`=6'b001100 and `err`=0.
- R5: `err` equals `e` XOR all six bits of `par`. With no fault, `err` equals `e`.
- R6: For every `sel`, every value of `e` and every `seed`, setting exactly one bit of `fault` drives `err` to the complement of `e`.
- R7: Bit 3k+j of `fault` inverts output j of cell k, where j=0 is the control pass-through. The decode lines carry the faulted outputs. For example, bit 4 flips `dec[2]` and bit 7 flips `dec[0]`.
- R8: `seed` changes neither `dec` nor `err`.
- R9: Two faults inside the same cell leave `err` equal to `e`, because an even number of flips escapes the parity check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel | input | 2 | Binary select code |
| seed | input | 3 | Per-cell parity seed, shared by both parity stages of the cell |
| e | input | 1 | Test-cell control bit; value of `err` when healthy |
| fault | input | 9 | Fault injection, bit 3k+j inverts output j of cell k |
| dec | output | 4 | One-hot decode lines |
| par | output | 6 | Parity pairs, `par[2k]` input side and `par[2k+1]` output side of cell k |
| err | output | 1 | Error flag |

## Verification
Decoding and fault detection act in the same evaluation. One input set both selects a
line and, through the fault vector, corrupts a gate output. The bench sweeps all
select codes against each single fault bit and both values of `e`. It judges `dec`
against the expected line pattern with the flip applied. It judges `err` against the
complement of `e`. The bench also confirms that the faulted line is the one R7 names.

// File: rtl/rev_decoder_ot.sv
module rev_decoder_ot #(
  parameter int NCELL = 3
) (
  input  logic [1:0]         sel,
  input  logic [NCELL-1:0]   seed,
  input  logic               e,
  input  logic [3*NCELL-1:0] fault,
  output logic [3:0]         dec,
  output logic [2*NCELL-1:0] par,
  output logic               err
);
  localparam int NFAULT = 3 * NCELL;

  logic a_s, b_s;
  logic [NCELL-1:0] c_ctl, c_b, c_c;
  logic [NFAULT-1:0] g_out, u_out;

  assign a_s = sel[1];
  assign b_s = sel[0];

  assign c_ctl = {b_s, b_s, a_s};
  assign c_b   = {~a_s, a_s, 1'b1};
  assign c_c   = {1'b0, 1'b0, 1'b0};

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    logic pin;
    assign g_out[3*k]   = c_ctl[k];
    assign g_out[3*k+1] = (~c_ctl[k] & c_b[k]) | (c_ctl[k] & c_c[k]);
    assign g_out[3*k+2] = (~c_ctl[k] & c_c[k]) | (c_ctl[k] & c_b[k]);
    assign u_out[3*k +: 3] = g_out[3*k +: 3] ^ fault[3*k +: 3];
    assign pin = c_ctl[k] ^ c_b[k] ^ c_c[k];
    assign par[2*k]   = seed[k] ^ pin;
    assign par[2*k+1] = seed[k] ^ (^u_out[3*k +: 3]);
  end

  assign dec = {u_out[5], u_out[4], u_out[8], u_out[7]};
  assign err = e ^ (^par);
endmodule

// File: rtl/rev_decoder_ot_chk.sv
module rev_decoder_ot_chk (
  input logic [1:0] sel,
  input logic [2:0] seed,
  input logic       e,
  input logic [8:0] fault,
  input logic [3:0] dec,
  input logic [5:0] par,
  input logic       err
);
  always_comb begin
    if (fault == 9'd0) begin
      AST_ONEHOT_DECODE: assert (dec == (4'b0001 << sel));                          // R1
      AST_PAIRS_AGREE: assert (par[0] == par[1] && par[2] == par[3] && par[4] == par[5]); // R3
      AST_FLAG_CLEAR: assert (err == e);                                            // R5
      AST_INPUT_PARITY: assert (par[0] == (seed[0] ^ ~sel[1]));                     // R3
    end
    if ($countones(fault) == 1) begin
      AST_SINGLE_FAULT_FLAG: assert (err == ~e);                                    // R6
    end
  end
endmodule

bind rev_decoder_ot rev_decoder_ot_chk u_chk (
  .sel(sel), .seed(seed), .e(e), .fault(fault),
  .dec(dec), .par(par), .err(err)
);

// File: tb/tb_rev_decoder_ot.sv
module tb_rev_decoder_ot;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0] sel;
  logic [2:0] seed;
  logic       e;
  logic [8:0] fault;
  logic [3:0] dec;
  logic [5:0] par;
  logic       err;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  rev_decoder_ot dut (.sel(sel), .seed(seed), .e(e), .fault(fault),
                      .dec(dec), .par(par), .err(err));

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] s, input logic [2:0] sd, input logic ee, input logic [8:0] f);
    @(posedge clk);
    sel = s; seed = sd; e = ee; fault = f;
    @(negedge clk);
  endtask

  function automatic logic [3:0] exp_dec(input logic [1:0] s, input logic [8:0] f);
    logic [3:0] d;
    d = 4'b0001 << s;
    d[0] ^= f[7]; d[1] ^= f[8]; d[2] ^= f[4]; d[3] ^= f[5];
    return d;
  endfunction

  function automatic logic [5:0] exp_par(input logic [1:0] s, input logic [2:0] sd, input logic [8:0] f);
    logic [2:0] ip;
    logic [5:0] p;
    ip[0] = s[1] ^ 1'b1;
    ip[1] = s[0] ^ s[1];
    ip[2] = s[0] ^ ~s[1];
    for (int k = 0; k < 3; k++) begin
      p[2*k]   = sd[k] ^ ip[k];
      p[2*k+1] = sd[k] ^ ip[k] ^ f[3*k] ^ f[3*k+1] ^ f[3*k+2];
    end
    return p;
  endfunction

  task automatic t_reset_state();
    drive(2'b00, 3'b000, 1'b0, 9'd0);
    chk("R1 reset dec", {5'd0, dec}, {5'd0, 4'b0001});
    chk("R3 reset par", {3'd0, par}, {3'd0, 6'b110011});
    chk("R5 reset err", {8'd0, err}, 9'd0);
  endtask

  task automatic t_decode();
    for (int s = 0; s < 4; s++) begin
      for (int ee = 0; ee < 2; ee++) begin
        drive(s[1:0], 3'b000, ee[0], 9'd0);
        chk("R1 decode", {5'd0, dec}, {5'd0, exp_dec(s[1:0], 9'd0)});
        chk("R2 cell outputs parity", {3'd0, par}, {3'd0, exp_par(s[1:0], 3'b000, 9'd0)});
        chk("R5 healthy flag", {8'd0, err}, {8'd0, ee[0]});
      end
    end
  endtask

  task automatic t_example();
    drive(2'b10, 3'b000, 1'b0, 9'd0);
    chk("R4 dec", {5'd0, dec}, {5'd0, 4'b0100});
    chk("R4 par", {3'd0, par}, {3'd0, 6'b001100});
    chk("R4 err", {8'd0, err}, 9'd0);
  endtask

  task automatic t_single_faults();
    for (int s = 0; s < 4; s++)
      for (int ee = 0; ee < 2; ee++)
        for (int sd = 0; sd < 8; sd += 5)
          for (int b = 0; b < 9; b++) begin
            drive(s[1:0], sd[2:0], ee[0], 9'd1 << b);
            chk("R6 single fault flag", {8'd0, err}, {8'd0, ~ee[0]});
            chk("R7 faulted dec", {5'd0, dec}, {5'd0, exp_dec(s[1:0], 9'd1 << b)});
            chk("R3 faulted par", {3'd0, par}, {3'd0, exp_par(s[1:0], sd[2:0], 9'd1 << b)});
          end
  endtask

  task automatic t_fault_map();
    drive(2'b00, 3'b000, 1'b0, 9'd1 << 4);
    chk("R7 bit4 flips dec2", {5'd0, dec}, {5'd0, 4'b0101});
    drive(2'b00, 3'b000, 1'b0, 9'd1 << 7);
    chk("R7 bit7 flips dec0", {5'd0, dec}, {5'd0, 4'b0000});
  endtask

  task automatic t_seed();
    for (int sd = 0; sd < 8; sd++) begin
      drive(2'b01, sd[2:0], 1'b0, 9'd0);
      chk("R8 seed dec", {5'd0, dec}, {5'd0, 4'b0010});
      chk("R8 seed err", {8'd0, err}, 9'd0);
      chk("R3 seed par", {3'd0, par}, {3'd0, exp_par(2'b01, sd[2:0], 9'd0)});
    end
  endtask

  task automatic t_double();
    for (int k = 0; k < 3; k++) begin
      drive(2'b11, 3'b010, 1'b0, 9'd3 << (3*k));
      chk("R9 double fault escapes", {8'd0, err}, 9'd0);
    end
  endtask

  initial begin
    sel = 2'b00; seed = 3'b000; e = 1'b0; fault = 9'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_decode();
    t_example();
    t_single_faults();
    t_fault_map();
    t_seed();
    t_double();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule